// File: doc/BRIEF.md
# UDP Socket Receive/Transmit Sequencer

This block runs after a network controller's socket has been opened. It moves UDP datagrams between that socket's buffers and two local byte streams. It talks to the controller only through a frame-engine request port. Each request names a register block, a 16-bit address, a direction and a byte count, and the engine then moves those bytes one at a time.

When no transmit is waiting, the sequencer keeps reading the socket's received-size register. When that register reads nonzero, the sequencer does the following:

- loads the receive read pointer from the controller into its own 16-bit register;
- streams the buffered bytes out, advancing the pointer once per byte;
- writes the advanced pointer back;
- issues the receive command.

A transmit request carries a byte count. It is served before the next poll:

- the free-space register is read, and the request is refused when the free space is smaller than the count;
- otherwise the transmit write pointer is fetched and the payload is pulled from the local stream into the transmit buffer;
- the pointer is advanced by the count and written back, and the send command is issued.

Socket opening and UDP header parsing are handled elsewhere. A transmit count must be nonzero.

Top module: `udp_socket_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `feReq`, `rxValid`, `rxLast`, `txPull`, `txDone` and `txReject` are all 0. The first request after reset is a received-size poll.
- R2: With no transmit pending, the block issues back-to-back 2-byte reads (`feWrite`=0, `feBlock`=1) of address 0x0026. While these reads return 0, no other request is made and `rxValid` stays 0.
- R3: After a poll returns a nonzero size S, the next request is a 2-byte read of address 0x0028 in block 1. The value read, taken high byte first, becomes the pointer P. The request after that is a read of S bytes from block 3 at address P.
- R4: Each byte delivered with `feRdValid` during the buffer read appears on `rxData` with `rxValid` one cycle later, in the same order. `rxLast` is 1 with the S-th byte only.
- R5: After the buffer read, the block writes P+S to address 0x0028 in block 1, as 2 bytes with the high byte first. It then writes the single byte 0x40 to address 0x0001 in block 1.
- R6: A transmit request of length L is served with a 2-byte read of address 0x0020 in block 1. If the value F is below L, `txReject` pulses for one cycle, no write request is made and `txPull` stays 0.
- R7: If F is at least L, the block reads the 2-byte pointer W at address 0x0024. It then writes L bytes to block 2 at address W. Each byte is taken from `txData`, with one `txPull` cycle per byte.
- R8: After the payload, the block writes W+L to address 0x0024 (high byte first), then the byte 0x20 to address 0x0001. `txDone` then pulses for one cycle, and `txDone` and `txReject` are never 1 together.
- R9: Once `feReq` is 1, it stays 1 until `feDone`. `feAddr`, `feLen`, `feWrite` and `feBlock` do not change while it waits.
- R10: Pointer arithmetic wraps modulo 2^16. For example, P=0xFFFE with S=5 writes back 0x0003.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| feReq | output | 1 | Frame request, held until feDone |
| feWrite | output | 1 | 1 = write to controller, 0 = read |
| feBlock | output | 5 | Register block: 1 socket registers, 2 TX buffer, 3 RX buffer |
| feAddr | output | 16 | Register or buffer address |
| feLen | output | 16 | Number of data bytes in the frame |
| feWrData | output | 8 | Byte for the current write position |
| feWrPull | input | 1 | Engine consumes feWrData this cycle |
| feRdData | input | 8 | Byte read from the controller |
| feRdValid | input | 1 | feRdData is valid this cycle |
| feDone | input | 1 | Frame finished (one cycle, after the last byte) |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | rxData valid |
| rxLast | output | 1 | Marks the final byte of a datagram |
| txReq | input | 1 | Transmit request, held until txDone or txReject |
| txLen | input | 16 | Transmit byte count, stable with txReq |
| txData | input | 8 | Payload byte at the current pull position |
| txPull | output | 1 | Current txData byte is consumed |
| txDone | output | 1 | One-cycle pulse: datagram handed to the controller |
| txReject | output | 1 | One-cycle pulse: not enough free space |

## Verification
Received bytes are registered, so each one is due on `rxData` exactly one cycle after its `feRdValid`. The bench captures them at the falling edge after that rising edge. `txPull` and `feWrData` are combinational on the pull cycle, so the bench engine samples them 1 ns after it raises `feWrPull`, before the next rising edge. `txDone` and `txReject` are due in the cycle after the `feDone` that ends the command write or the free-space read. The bench counts these pulses at falling edges and releases `txReq` on the first one. Frame attributes are captured when the engine accepts a request and compared later against the expected sequence.

// File: rtl/udp_socket_seq_pkg.sv
package udp_socket_seq_pkg;

  localparam int BYTE_W = 8;

  // register block codes decoded by the frame engine
  localparam logic [4:0] BLK_SOCK  = 5'd1;
  localparam logic [4:0] BLK_TXBUF = 5'd2;
  localparam logic [4:0] BLK_RXBUF = 5'd3;

  // socket command bytes
  localparam logic [BYTE_W-1:0] CMD_RECV = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_SEND = 8'h20;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_RDPTR,
    ST_RDBUF,
    ST_WRPTR,
    ST_RXCMD,
    ST_FREE,
    ST_TXPTR,
    ST_WRBUF,
    ST_TXWPTR,
    ST_TXCMD
  } seqState_t;

  typedef struct packed {
    logic clrCount;
    logic latchRxSize;
    logic latchRxPtr;
    logic latchTxPtr;
    logic latchTxLen;
    logic addTxLen;
  } dpStrobe_t;

endpackage

// File: rtl/udp_socket_seq_ctrl.sv
module udp_socket_seq_ctrl
  import udp_socket_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      feDone,
  input  logic      txReq,
  input  logic      rxSizeZero,
  input  logic      txFits,
  output seqState_t state,
  output dpStrobe_t stb,
  output logic      txDone,
  output logic      txReject
);

  seqState_t nextState;

  always_comb begin
    nextState    = state;
    stb          = '0;
    stb.clrCount = feDone;
    unique case (state)
      ST_IDLE: begin
        if (txReq) begin
          nextState      = ST_FREE;
          stb.latchTxLen = 1'b1;
        end else begin
          nextState = ST_POLL;
        end
      end
      ST_POLL: if (feDone) begin
        nextState       = rxSizeZero ? ST_IDLE : ST_RDPTR;
        stb.latchRxSize = !rxSizeZero;
      end
      ST_RDPTR: if (feDone) begin
        nextState      = ST_RDBUF;
        stb.latchRxPtr = 1'b1;
      end
      ST_RDBUF:  if (feDone) nextState = ST_WRPTR;
      ST_WRPTR:  if (feDone) nextState = ST_RXCMD;
      ST_RXCMD:  if (feDone) nextState = ST_IDLE;
      ST_FREE:   if (feDone) nextState = txFits ? ST_TXPTR : ST_IDLE;
      ST_TXPTR: if (feDone) begin
        nextState      = ST_WRBUF;
        stb.latchTxPtr = 1'b1;
      end
      ST_WRBUF: if (feDone) begin
        nextState    = ST_TXWPTR;
        stb.addTxLen = 1'b1;
      end
      ST_TXWPTR: if (feDone) nextState = ST_TXCMD;
      ST_TXCMD:  if (feDone) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      txDone   <= 1'b0;
      txReject <= 1'b0;
    end else begin
      state    <= nextState;
      txDone   <= (state == ST_TXCMD) && feDone;
      txReject <= (state == ST_FREE) && feDone && !txFits;
    end
  end

endmodule

// File: rtl/udp_socket_seq_dp.sv
module udp_socket_seq_dp
  import udp_socket_seq_pkg::*;
#(
  parameter int               PTR_W       = 16,
  parameter logic [PTR_W-1:0] RXSIZE_ADDR = 16'h0026,
  parameter logic [PTR_W-1:0] RXRD_ADDR   = 16'h0028,
  parameter logic [PTR_W-1:0] TXFREE_ADDR = 16'h0020,
  parameter logic [PTR_W-1:0] TXWR_ADDR   = 16'h0024,
  parameter logic [PTR_W-1:0] CMD_ADDR    = 16'h0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqState_t         state,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] feRdData,
  input  logic              feRdValid,
  input  logic              feWrPull,
  input  logic [PTR_W-1:0]  txLen,
  input  logic [BYTE_W-1:0] txData,
  output logic              feReq,
  output logic              feWrite,
  output logic [4:0]        feBlock,
  output logic [PTR_W-1:0]  feAddr,
  output logic [PTR_W-1:0]  feLen,
  output logic [BYTE_W-1:0] feWrData,
  output logic              txPull,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxLast,
  output logic              rxSizeZero,
  output logic              txFits
);

  localparam int               PTR_BYTES = PTR_W / BYTE_W;
  localparam logic [PTR_W-1:0] REG_LEN   = PTR_W'(PTR_BYTES);
  localparam logic [PTR_W-1:0] CMD_LEN   = PTR_W'(1);

  logic [PTR_W-1:0] rdWord;
  logic [PTR_W-1:0] byteCnt;
  logic [PTR_W-1:0] rxSizeQ;
  logic [PTR_W-1:0] rxPtr;
  logic [PTR_W-1:0] rxBase;
  logic [PTR_W-1:0] txPtr;
  logic [PTR_W-1:0] txLenQ;

  // pick byte idx of a pointer word, most significant byte at idx 0
  function automatic logic [BYTE_W-1:0] selByte(input logic [PTR_W-1:0] w,
                                                input logic [PTR_W-1:0] idx);
    logic [PTR_W-1:0] shifted;
    shifted = w >> (BYTE_W * (PTR_BYTES - 1 - int'(idx)));
    return shifted[BYTE_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWord  <= '0;
      byteCnt <= '0;
    end else begin
      if (feRdValid) rdWord <= {rdWord[PTR_W-BYTE_W-1:0], feRdData};
      if (stb.clrCount)               byteCnt <= '0;
      else if (feRdValid || feWrPull) byteCnt <= byteCnt + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSizeQ <= '0;
      rxPtr   <= '0;
      rxBase  <= '0;
      txPtr   <= '0;
      txLenQ  <= '0;
    end else begin
      if (stb.latchRxSize) rxSizeQ <= rdWord;
      if (stb.latchRxPtr) begin
        rxPtr  <= rdWord;
        rxBase <= rdWord;
      end else if (state == ST_RDBUF && feRdValid) begin
        rxPtr <= rxPtr + PTR_W'(1);
      end
      if (stb.latchTxLen) txLenQ <= txLen;
      if (stb.latchTxPtr)    txPtr <= rdWord;
      else if (stb.addTxLen) txPtr <= txPtr + txLenQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      rxLast  <= 1'b0;
    end else begin
      rxValid <= (state == ST_RDBUF) && feRdValid;
      rxLast  <= (state == ST_RDBUF) && feRdValid && (byteCnt == rxSizeQ - PTR_W'(1));
      if ((state == ST_RDBUF) && feRdValid) rxData <= feRdData;
    end
  end

  always_comb begin
    feReq    = (state != ST_IDLE);
    feWrite  = 1'b0;
    feBlock  = BLK_SOCK;
    feAddr   = '0;
    feLen    = REG_LEN;
    feWrData = '0;
    unique case (state)
      ST_POLL:  feAddr = RXSIZE_ADDR;
      ST_RDPTR: feAddr = RXRD_ADDR;
      ST_RDBUF: begin
        feBlock = BLK_RXBUF;
        feAddr  = rxBase;
        feLen   = rxSizeQ;
      end
      ST_WRPTR: begin
        feWrite  = 1'b1;
        feAddr   = RXRD_ADDR;
        feWrData = selByte(rxPtr, byteCnt);
      end
      ST_RXCMD: begin
        feWrite  = 1'b1;
        feAddr   = CMD_ADDR;
        feLen    = CMD_LEN;
        feWrData = CMD_RECV;
      end
      ST_FREE:  feAddr = TXFREE_ADDR;
      ST_TXPTR: feAddr = TXWR_ADDR;
      ST_WRBUF: begin
        feWrite  = 1'b1;
        feBlock  = BLK_TXBUF;
        feAddr   = txPtr;
        feLen    = txLenQ;
        feWrData = txData;
      end
      ST_TXWPTR: begin
        feWrite  = 1'b1;
        feAddr   = TXWR_ADDR;
        feWrData = selByte(txPtr, byteCnt);
      end
      ST_TXCMD: begin
        feWrite  = 1'b1;
        feAddr   = CMD_ADDR;
        feLen    = CMD_LEN;
        feWrData = CMD_SEND;
      end
      default: ;
    endcase
  end

  assign txPull     = feWrPull && (state == ST_WRBUF);
  assign rxSizeZero = (rdWord == '0);
  assign txFits     = (rdWord >= txLenQ);

endmodule

// File: rtl/udp_socket_seq.sv
module udp_socket_seq
  import udp_socket_seq_pkg::*;
#(
  parameter int               PTR_W       = 16,
  parameter logic [PTR_W-1:0] RXSIZE_ADDR = 16'h0026,
  parameter logic [PTR_W-1:0] RXRD_ADDR   = 16'h0028,
  parameter logic [PTR_W-1:0] TXFREE_ADDR = 16'h0020,
  parameter logic [PTR_W-1:0] TXWR_ADDR   = 16'h0024,
  parameter logic [PTR_W-1:0] CMD_ADDR    = 16'h0001
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              feReq,
  output logic              feWrite,
  output logic [4:0]        feBlock,
  output logic [PTR_W-1:0]  feAddr,
  output logic [PTR_W-1:0]  feLen,
  output logic [BYTE_W-1:0] feWrData,
  input  logic              feWrPull,
  input  logic [BYTE_W-1:0] feRdData,
  input  logic              feRdValid,
  input  logic              feDone,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxLast,
  input  logic              txReq,
  input  logic [PTR_W-1:0]  txLen,
  input  logic [BYTE_W-1:0] txData,
  output logic              txPull,
  output logic              txDone,
  output logic              txReject
);

  seqState_t state;
  dpStrobe_t stb;
  logic      rxSizeZero;
  logic      txFits;

  udp_socket_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .feDone     (feDone),
    .txReq      (txReq),
    .rxSizeZero (rxSizeZero),
    .txFits     (txFits),
    .state      (state),
    .stb        (stb),
    .txDone     (txDone),
    .txReject   (txReject)
  );

  udp_socket_seq_dp #(
    .PTR_W       (PTR_W),
    .RXSIZE_ADDR (RXSIZE_ADDR),
    .RXRD_ADDR   (RXRD_ADDR),
    .TXFREE_ADDR (TXFREE_ADDR),
    .TXWR_ADDR   (TXWR_ADDR),
    .CMD_ADDR    (CMD_ADDR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .state      (state),
    .stb        (stb),
    .feRdData   (feRdData),
    .feRdValid  (feRdValid),
    .feWrPull   (feWrPull),
    .txLen      (txLen),
    .txData     (txData),
    .feReq      (feReq),
    .feWrite    (feWrite),
    .feBlock    (feBlock),
    .feAddr     (feAddr),
    .feLen      (feLen),
    .feWrData   (feWrData),
    .txPull     (txPull),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxLast     (rxLast),
    .rxSizeZero (rxSizeZero),
    .txFits     (txFits)
  );

endmodule

// File: rtl/udp_socket_seq_chk.sv
module udp_socket_seq_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             feReq,
  input logic             feWrite,
  input logic [4:0]       feBlock,
  input logic [PTR_W-1:0] feAddr,
  input logic [PTR_W-1:0] feLen,
  input logic             feRdValid,
  input logic             feDone,
  input logic             rxValid,
  input logic             rxLast,
  input logic             txPull,
  input logic             txDone,
  input logic             txReject
);

  p_req_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (feReq && !feDone) |=> feReq);

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (feReq && !feDone) |=> ($stable(feAddr) && $stable(feLen) &&
                            $stable(feWrite) && $stable(feBlock)));

  p_last_in_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxLast |-> rxValid);

  p_rx_follows_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(feRdValid));

  p_pull_on_txbuf_r7: assert property (@(posedge clk) disable iff (!rstN)
    txPull |-> (feReq && feWrite && feBlock == 5'd2));

  p_ack_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(txDone && txReject));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  p_reject_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    txReject |=> !txReject);

  p_ack_when_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txDone || txReject) |-> !feReq);

endmodule

bind udp_socket_seq udp_socket_seq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .feReq     (feReq),
  .feWrite   (feWrite),
  .feBlock   (feBlock),
  .feAddr    (feAddr),
  .feLen     (feLen),
  .feRdValid (feRdValid),
  .feDone    (feDone),
  .rxValid   (rxValid),
  .rxLast    (rxLast),
  .txPull    (txPull),
  .txDone    (txDone),
  .txReject  (txReject)
);

// File: tb/udp_socket_seq_test.sv
`timescale 1ns/1ps
module udp_socket_seq_test;

  localparam logic [15:0] A_RXSIZE = 16'h0026;
  localparam logic [15:0] A_RXRD   = 16'h0028;
  localparam logic [15:0] A_TXFREE = 16'h0020;
  localparam logic [15:0] A_TXWR   = 16'h0024;
  localparam logic [15:0] A_CMD    = 16'h0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        feReq, feWrite;
  logic [4:0]  feBlock;
  logic [15:0] feAddr, feLen;
  logic [7:0]  feWrData;
  logic        feWrPull = 1'b0;
  logic [7:0]  feRdData = 8'h00;
  logic        feRdValid = 1'b0;
  logic        feDone = 1'b0;
  logic [7:0]  rxData;
  logic        rxValid, rxLast;
  logic        txReq = 1'b0;
  logic [15:0] txLen = 16'h0;
  logic [7:0]  txData;
  logic        txPull, txDone, txReject;

  always #2 clk = ~clk;

  udp_socket_seq uut (
    .clk(clk), .rstN(rstN), .feReq(feReq), .feWrite(feWrite), .feBlock(feBlock),
    .feAddr(feAddr), .feLen(feLen), .feWrData(feWrData), .feWrPull(feWrPull),
    .feRdData(feRdData), .feRdValid(feRdValid), .feDone(feDone),
    .rxData(rxData), .rxValid(rxValid), .rxLast(rxLast),
    .txReq(txReq), .txLen(txLen), .txData(txData), .txPull(txPull),
    .txDone(txDone), .txReject(txReject)
  );

  int checks = 0;
  int errors = 0;

  // controller model state
  logic        hold = 1'b1;
  logic        engBusy = 1'b0;
  logic [15:0] rxSizeVal = 16'h0;
  logic [15:0] rxRdReg = 16'h0;
  logic [15:0] txFreeVal = 16'h0;
  logic [15:0] txWrReg = 16'h0;
  int          recvCmdCount = 0;
  int          sendCmdCount = 0;
  int          pullCount = 0;
  int          txIdx = 0;
  logic [7:0]  txSeed = 8'h0;
  logic [7:0]  txCap [0:255];

  int          opN = 0;
  logic [15:0] opAddr [0:63];
  logic [4:0]  opBlk  [0:63];
  logic        opWr   [0:63];
  logic [15:0] opLen  [0:63];
  logic [7:0]  opB0   [0:63];

  int          rxCnt = 0;
  int          lastCount = 0;
  int          lastIdx = -1;
  logic [7:0]  rxCap [0:255];
  int          doneCount = 0;
  int          rejCount = 0;

  function automatic logic [7:0] byteAt(input logic [15:0] a);
    return 8'(a[7:0] * 3) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] txPat(input logic [7:0] seed, input int i);
    return 8'(seed + 8'(i * 7));
  endfunction

  function automatic logic [7:0] readByte(input logic [15:0] a, input logic [4:0] b, input int i);
    logic [15:0] v;
    if (b == 5'd3) return byteAt(a + 16'(i));
    case (a)
      A_RXSIZE: v = rxSizeVal;
      A_RXRD:   v = rxRdReg;
      A_TXFREE: v = txFreeVal;
      A_TXWR:   v = txWrReg;
      default:  v = 16'h0;
    endcase
    return (i == 0) ? v[15:8] : v[7:0];
  endfunction

  assign txData = txPat(txSeed, txIdx);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // frame engine model
  initial begin : engine
    logic [15:0] a, n;
    logic [4:0]  b;
    logic        w;
    logic [7:0]  wb [0:255];
    logic [7:0]  first;
    forever begin
      @(negedge clk);
      if (rstN && feReq && !hold) begin
        engBusy = 1'b1;
        a = feAddr; b = feBlock; w = feWrite; n = feLen; first = 8'h00;
        @(negedge clk);
        for (int i = 0; i < int'(n); i++) begin
          if (w) begin
            feWrPull = 1'b1;
            #1;
            if (txPull) pullCount++;
            if (i < 256) wb[i] = feWrData;
            if (i == 0) first = feWrData;
            if (b == 5'd2) begin
              if (i < 256) txCap[i] = feWrData;
              txIdx++;
            end
          end else begin
            feRdData  = readByte(a, b, i);
            feRdValid = 1'b1;
            if (i == 0) first = feRdData;
          end
          @(negedge clk);
          feWrPull  = 1'b0;
          feRdValid = 1'b0;
        end
        if (w && b == 5'd1) begin
          if (a == A_RXRD) rxRdReg = {wb[0], wb[1]};
          if (a == A_TXWR) txWrReg = {wb[0], wb[1]};
          if (a == A_CMD && wb[0] == 8'h40) begin rxSizeVal = 16'h0; recvCmdCount++; end
          if (a == A_CMD && wb[0] == 8'h20) sendCmdCount++;
        end
        if (opN < 64) begin
          opAddr[opN] = a; opBlk[opN] = b; opWr[opN] = w; opLen[opN] = n; opB0[opN] = first;
        end
        opN++;
        feDone = 1'b1;
        @(negedge clk);
        feDone  = 1'b0;
        engBusy = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rxValid) begin
      if (rxCnt < 256) rxCap[rxCnt] = rxData;
      if (rxLast) begin lastCount++; lastIdx = rxCnt; end
      rxCnt++;
    end
    if (txDone) doneCount++;
    if (txReject) rejCount++;
  end

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pauseEngine();
    hold = 1'b1;
    @(negedge clk);
    while (engBusy) @(negedge clk);
  endtask

  task automatic runPoll();
    pauseEngine();
    rxSizeVal = 16'h0; opN = 0; rxCnt = 0;
    hold = 1'b0;
    repeat (120) @(negedge clk);
    check(opN >= 5, "R2 poll count", opN, 5);
    for (int i = 0; i < opN && i < 64; i++)
      check(opAddr[i] == A_RXSIZE && !opWr[i] && opBlk[i] == 5'd1 && opLen[i] == 16'd2,
            "R2 only polls", int'(opAddr[i]), int'(A_RXSIZE));
    check(rxCnt == 0, "R2 no rx output", rxCnt, 0);
  endtask

  task automatic runRx(input logic [15:0] ptr, input logic [15:0] size);
    int k, bad, t;
    pauseEngine();
    rxRdReg = ptr; rxSizeVal = size; opN = 0; rxCnt = 0; lastCount = 0; lastIdx = -1;
    recvCmdCount = 0;
    hold = 1'b0;
    t = 0;
    while (recvCmdCount == 0 && t < 3000) begin @(negedge clk); t++; end
    check(recvCmdCount == 1, "R5 receive command seen", recvCmdCount, 1);
    repeat (4) @(negedge clk);
    k = -1;
    for (int i = 0; i < opN && i < 60; i++)
      if (k < 0 && opAddr[i] == A_RXRD && !opWr[i]) k = i;
    check(k >= 1, "R3 pointer read found", k, 1);
    if (k >= 1) begin
      check(opAddr[k-1] == A_RXSIZE && !opWr[k-1], "R3 preceded by poll", int'(opAddr[k-1]), int'(A_RXSIZE));
      check(opBlk[k+1] == 5'd3 && !opWr[k+1] && opAddr[k+1] == ptr && opLen[k+1] == size,
            "R3 buffer read at pointer", int'(opAddr[k+1]), int'(ptr));
      check(opWr[k+2] && opAddr[k+2] == A_RXRD && opLen[k+2] == 16'd2 && opB0[k+2] == 8'(16'(ptr + size) >> 8),
            "R5 pointer write high first", int'(opB0[k+2]), int'(8'(16'(ptr + size) >> 8)));
      check(opWr[k+3] && opAddr[k+3] == A_CMD && opLen[k+3] == 16'd1 && opB0[k+3] == 8'h40,
            "R5 command 0x40", int'(opB0[k+3]), 'h40);
    end
    check(rxCnt == int'(size), "R4 byte count", rxCnt, int'(size));
    bad = 0;
    for (int i = 0; i < int'(size) && i < 256; i++)
      if (rxCap[i] !== byteAt(ptr + 16'(i))) bad++;
    check(bad == 0, "R4 byte values", bad, 0);
    check(lastCount == 1 && lastIdx == int'(size) - 1, "R4 last marker", lastIdx, int'(size) - 1);
    check(rxRdReg == 16'(ptr + size), "R10 written pointer", int'(rxRdReg), int'(16'(ptr + size)));
  endtask

  task automatic runTx(input logic [15:0] len, input logic [15:0] free,
                       input logic [15:0] wr, input logic [7:0] seed);
    int k, bad, t;
    bit expRej;
    bit writes;
    expRej = (free < len);
    pauseEngine();
    rxSizeVal = 16'h0; txFreeVal = free; txWrReg = wr; opN = 0; pullCount = 0;
    txIdx = 0; txSeed = seed; doneCount = 0; rejCount = 0; sendCmdCount = 0;
    txLen = len; txReq = 1'b1;
    hold = 1'b0;
    t = 0;
    while (!(txDone || txReject) && t < 3000) begin @(negedge clk); t++; end
    txReq = 1'b0;
    repeat (6) @(negedge clk);
    k = -1;
    for (int i = 0; i < opN && i < 59; i++)
      if (k < 0 && opAddr[i] == A_TXFREE && !opWr[i]) k = i;
    check(k >= 0, "R6 free-space read", k, 0);
    if (expRej) begin
      check(rejCount == 1 && doneCount == 0, "R6 reject pulse", rejCount, 1);
      check(pullCount == 0, "R6 no pull", pullCount, 0);
      writes = 1'b0;
      for (int i = 0; i < opN && i < 64; i++) if (opWr[i]) writes = 1'b1;
      check(!writes, "R6 no write frames", int'(writes), 0);
      check(txWrReg == wr, "R6 pointer untouched", int'(txWrReg), int'(wr));
    end else begin
      check(doneCount == 1 && rejCount == 0, "R8 done pulse", doneCount, 1);
      if (k >= 0) begin
        check(opAddr[k+1] == A_TXWR && !opWr[k+1], "R7 pointer read", int'(opAddr[k+1]), int'(A_TXWR));
        check(opWr[k+2] && opBlk[k+2] == 5'd2 && opAddr[k+2] == wr && opLen[k+2] == len,
              "R7 buffer write at pointer", int'(opAddr[k+2]), int'(wr));
        check(opWr[k+3] && opAddr[k+3] == A_TXWR && opB0[k+3] == 8'(16'(wr + len) >> 8),
              "R8 pointer write high first", int'(opB0[k+3]), int'(8'(16'(wr + len) >> 8)));
        check(opWr[k+4] && opAddr[k+4] == A_CMD && opB0[k+4] == 8'h20,
              "R8 command 0x20", int'(opB0[k+4]), 'h20);
      end
      check(pullCount == int'(len), "R7 pull count", pullCount, int'(len));
      bad = 0;
      for (int i = 0; i < int'(len) && i < 256; i++)
        if (txCap[i] !== txPat(seed, i)) bad++;
      check(bad == 0, "R7 payload bytes", bad, 0);
      check(txWrReg == 16'(wr + len), "R10 tx pointer", int'(txWrReg), int'(16'(wr + len)));
    end
  endtask

  initial begin : main
    logic [15:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!feReq && !rxValid && !rxLast && !txPull && !txDone && !txReject,
          "R1 outputs in reset", int'(feReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!rxValid && !txDone && !txReject && !txPull, "R1 quiet after reset", int'(rxValid), 0);
    hold = 1'b0;
    @(negedge clk);
    check(feReq && feAddr == A_RXSIZE && !feWrite, "R1 first request is poll", int'(feAddr), int'(A_RXSIZE));

    runPoll();
    runRx(16'h0100, 16'd8);
    runRx(16'hFFFE, 16'd5);
    runRx(16'h1234, 16'd1);
    runTx(16'd20, 16'd20, 16'hFFF0, 8'h11);
    runTx(16'd20, 16'd19, 16'h0040, 8'h22);
    runTx(16'd1, 16'd1000, 16'h0000, 8'h33);
    runTx(16'd5, 16'd0, 16'h1000, 8'h44);
    for (int it = 0; it < 8; it++) begin
      r = 16'($urandom);
      runRx(r, 16'(1 + $urandom % 48));
      runTx(16'(1 + $urandom % 40), 16'($urandom % 60), 16'($urandom), 8'($urandom));
    end
    runPoll();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule